// File: doc/BRIEF.md
# SerDes Lane Control Register File

This block is the register front end for one serial lane. A host reaches it through a small request/response port with 32-bit data. Behind that port sit four words: receive control, hardware init, lane status and interrupt status. Each control bit of the receive-control and init words drives a lane pin directly. The lane answers through discrete handshake inputs.

The lane's completion handshakes clear the calibration and transmit-enable request bits on their own. Software can therefore start a step and then poll the same bit until it reads back as zero. A link-up pulse from the lane sets a sticky interrupt status bit, and the host clears that bit by writing back the value it read.

The receive control word comes out of reset with its power-down controls asserted. The lane therefore stays idle until software brings it up.

Top module: `lane_ctl_regs`

## Requirements
- R1: After reset the receive control word reads 0x000000F0 (pins: sleep=2'b11, iddq=1, aux_iddq=1, all others 0), and the init and interrupt words read 0.
- R2: A write to receive control (offset 0x801C) stores wdata & 0x800007F1. Other bits read 0. The pins follow the stored bits: 31 override, 10 PCS ready, 9 CDR reset, 8 calibration enable, 7:6 sleep, 5 aux IDDQ, 4 IDDQ, 0 data enable.
- R3: A lane_cal_done pulse clears calibration enable (bit 8) one cycle later. A host write to receive control in the same cycle takes priority.
- R4: A write to init control (offset 0x8020) stores wdata & 0x5 (bit 0 TX enable, bit 2 RX enable). A lane_tx_done pulse clears only bit 0 one cycle later, and a same-cycle host write takes priority.
- R5: Lane status (offset 0x8044) reads lane_tx_up in bit 0 and zero elsewhere. Writes to it have no effect.
- R6: Interrupt status (offset 0x8050) bit 6 is set by a lane_link_pulse and stays set. A write with bit 6 = 1 clears it, and a write with bit 6 = 0 leaves it unchanged. If a pulse and a clearing write arrive in the same cycle, the bit stays set.
- R7: Reads of unmapped offsets return 0. Writes to unmapped offsets change no register and still receive a response.
- R8: host_ready is high once reset has been released. Each accepted request produces rsp_valid in the following cycle and no other. For a read, rsp_rdata carries the register value as it was when the request was accepted. For a write, rsp_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Request valid |
| host_ready | output | 1 | Request can be accepted |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Byte offset |
| host_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| lane_tx_up | input | 1 | Transmit side powered up (level) |
| lane_tx_done | input | 1 | Transmit init finished (pulse) |
| lane_cal_done | input | 1 | Receive calibration finished (pulse) |
| lane_link_pulse | input | 1 | Link came up (pulse) |
| pin_sw_ovrd | output | 1 | Software override |
| pin_pcs_rdy | output | 1 | PCS-to-PHY ready |
| pin_cdr_rst | output | 1 | CDR reset |
| pin_cal_en | output | 1 | Calibration request |
| pin_sleep | output | 2 | Receive sleep control |
| pin_aux_iddq | output | 1 | Auxiliary power-down |
| pin_iddq | output | 1 | Receive power-down |
| pin_data_en | output | 1 | Receive data enable |
| pin_tx_en | output | 1 | Transmit init request |
| pin_rx_en | output | 1 | Receive init request |

## Verification
A faulty stored control bit appears on its lane pin on the clock edge after the write or handshake. It also appears in the read response one cycle after the next read. A self-clear that drops out or fires on the wrong bit leaves a request pin high, or drops a neighbouring pin, by the following cycle. A faulty sticky bit is only visible through a later read. For that reason the bench reads the interrupt word right after each pulse and after each clearing write.

// File: rtl/lane_ctl_pkg.sv
package lane_ctl_pkg;
  localparam int DW = 32;

  // receive control bit positions (decoded by the lane)
  localparam int RX_OVRD   = 31;
  localparam int RX_PCSRDY = 10;
  localparam int RX_CDRRST = 9;
  localparam int RX_CAL    = 8;
  localparam int RX_SLP_HI = 7;
  localparam int RX_SLP_LO = 6;
  localparam int RX_AUX    = 5;
  localparam int RX_IDDQ   = 4;
  localparam int RX_DEN    = 0;

  localparam int INIT_TX = 0;
  localparam int INIT_RX = 2;
  localparam int STAT_TXUP = 0;
  localparam int IRQ_LINK  = 6;

  localparam logic [DW-1:0] RX_MASK   = 32'h8000_07F1;
  localparam logic [DW-1:0] RX_RST    = 32'h0000_00F0;
  localparam logic [DW-1:0] INIT_MASK = 32'h0000_0005;
  localparam logic [DW-1:0] IRQ_MASK  = 32'h0000_0040;

  typedef enum logic [2:0] {SEL_NONE, SEL_RX, SEL_INIT, SEL_STAT, SEL_IRQ} reg_sel_e;
endpackage

// File: rtl/lane_ctl_selfclr_reg.sv
module lane_ctl_selfclr_reg #(
  parameter int              DATA_W  = 32,
  parameter logic [DATA_W-1:0] MASK    = '1,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  parameter int              CLR_BIT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              clr,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_nxt;
  logic              q_en;

  always_comb begin
    q_en  = wr_en | clr;
    q_nxt = q;
    if (wr_en) begin
      q_nxt = wdata & MASK;
    end else if (clr) begin
      q_nxt[CLR_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_VAL;
    end else if (q_en) begin
      q <= q_nxt;
    end
  end
endmodule

// File: rtl/lane_ctl_sticky.sv
module lane_ctl_sticky #(
  parameter int                DATA_W = 32,
  parameter logic [DATA_W-1:0] MASK   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] set,
  output logic [DATA_W-1:0] q
);
  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (MASK[i]) begin : g_flop
      logic r;
      logic r_nxt;
      logic r_en;
      always_comb begin
        r_en  = set[i] | wr_en;
        r_nxt = set[i] | (r & ~(wr_en & wdata[i]));
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          r <= 1'b0;
        end else if (r_en) begin
          r <= r_nxt;
        end
      end
      assign q[i] = r;
    end else begin : g_zero
      logic unused_b;
      assign unused_b = wdata[i] ^ set[i];
      assign q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/lane_ctl_regs.sv
module lane_ctl_regs
  import lane_ctl_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OFF_RX   = 'h801C,
  parameter int OFF_INIT = 'h8020,
  parameter int OFF_STAT = 'h8044,
  parameter int OFF_IRQ  = 'h8050
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              lane_tx_up,
  input  logic              lane_tx_done,
  input  logic              lane_cal_done,
  input  logic              lane_link_pulse,
  output logic              pin_sw_ovrd,
  output logic              pin_pcs_rdy,
  output logic              pin_cdr_rst,
  output logic              pin_cal_en,
  output logic [1:0]        pin_sleep,
  output logic              pin_aux_iddq,
  output logic              pin_iddq,
  output logic              pin_data_en,
  output logic              pin_tx_en,
  output logic              pin_rx_en
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  logic          acc;
  reg_sel_e      sel;
  logic [DW-1:0] rx_q, init_q, irq_q, stat_w, rd_mux, rdata_nxt;
  logic          irq_link;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n  = rst_sync[1];
  assign host_ready = rst_int_n;
  assign acc        = host_valid & host_ready;

  always_comb begin
    if      (host_addr == ADDR_W'(OFF_RX))   sel = SEL_RX;
    else if (host_addr == ADDR_W'(OFF_INIT)) sel = SEL_INIT;
    else if (host_addr == ADDR_W'(OFF_STAT)) sel = SEL_STAT;
    else if (host_addr == ADDR_W'(OFF_IRQ))  sel = SEL_IRQ;
    else                                     sel = SEL_NONE;
  end

  lane_ctl_selfclr_reg #(
    .DATA_W(DW), .MASK(RX_MASK), .RST_VAL(RX_RST), .CLR_BIT(RX_CAL)
  ) u_rx (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(acc & host_write & (sel == SEL_RX)),
    .wdata(host_wdata), .clr(lane_cal_done), .q(rx_q)
  );

  lane_ctl_selfclr_reg #(
    .DATA_W(DW), .MASK(INIT_MASK), .RST_VAL('0), .CLR_BIT(INIT_TX)
  ) u_init (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(acc & host_write & (sel == SEL_INIT)),
    .wdata(host_wdata), .clr(lane_tx_done), .q(init_q)
  );

  lane_ctl_sticky #(
    .DATA_W(DW), .MASK(IRQ_MASK)
  ) u_irq (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(acc & host_write & (sel == SEL_IRQ)),
    .wdata(host_wdata),
    .set(DW'(lane_link_pulse) << IRQ_LINK),
    .q(irq_q)
  );
  assign irq_link = irq_q[IRQ_LINK];

  always_comb begin
    stat_w            = '0;
    stat_w[STAT_TXUP] = lane_tx_up;
    unique case (sel)
      SEL_RX:   rd_mux = rx_q;
      SEL_INIT: rd_mux = init_q;
      SEL_STAT: rd_mux = stat_w;
      SEL_IRQ:  rd_mux = irq_q;
      default:  rd_mux = '0;
    endcase
    rdata_nxt = (acc && !host_write) ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= acc;
      rsp_rdata <= rdata_nxt;
    end
  end

  assign pin_sw_ovrd  = rx_q[RX_OVRD];
  assign pin_pcs_rdy  = rx_q[RX_PCSRDY];
  assign pin_cdr_rst  = rx_q[RX_CDRRST];
  assign pin_cal_en   = rx_q[RX_CAL];
  assign pin_sleep    = rx_q[RX_SLP_HI:RX_SLP_LO];
  assign pin_aux_iddq = rx_q[RX_AUX];
  assign pin_iddq     = rx_q[RX_IDDQ];
  assign pin_data_en  = rx_q[RX_DEN];
  assign pin_tx_en    = init_q[INIT_TX];
  assign pin_rx_en    = init_q[INIT_RX];
endmodule

// File: rtl/lane_ctl_regs_chk.sv
module lane_ctl_regs_chk #(
  parameter int ADDR_W   = 16,
  parameter int OFF_RX   = 'h801C,
  parameter int OFF_INIT = 'h8020,
  parameter int OFF_IRQ  = 'h8050
) (
  input logic              clk,
  input logic              rst_int_n,
  input logic              host_valid,
  input logic              host_ready,
  input logic              host_write,
  input logic [ADDR_W-1:0] host_addr,
  input logic [31:0]       host_wdata,
  input logic              rsp_valid,
  input logic              lane_cal_done,
  input logic              lane_tx_done,
  input logic              lane_link_pulse,
  input logic              pin_cal_en,
  input logic              pin_tx_en,
  input logic              irq_link
);
  logic acc, wr_rx, wr_init, wr_irq;
  assign acc     = host_valid && host_ready;
  assign wr_rx   = acc && host_write && (host_addr == ADDR_W'(OFF_RX));
  assign wr_init = acc && host_write && (host_addr == ADDR_W'(OFF_INIT));
  assign wr_irq  = acc && host_write && (host_addr == ADDR_W'(OFF_IRQ));

  p_rsp_after_acc_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    acc |=> rsp_valid);
  p_no_spurious_rsp_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !acc |=> !rsp_valid);
  p_cal_selfclr_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lane_cal_done && !wr_rx) |=> !pin_cal_en);
  p_cal_write_wins_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_rx && host_wdata[8]) |=> pin_cal_en);
  p_tx_selfclr_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (lane_tx_done && !wr_init) |=> !pin_tx_en);
  p_link_set_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    lane_link_pulse |=> irq_link);
  p_link_holds_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_link && !(wr_irq && host_wdata[6])) |=> irq_link);
endmodule

bind lane_ctl_regs lane_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .OFF_RX(OFF_RX), .OFF_INIT(OFF_INIT), .OFF_IRQ(OFF_IRQ)
) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .host_valid(host_valid),
  .host_ready(host_ready), .host_write(host_write), .host_addr(host_addr),
  .host_wdata(host_wdata), .rsp_valid(rsp_valid),
  .lane_cal_done(lane_cal_done), .lane_tx_done(lane_tx_done),
  .lane_link_pulse(lane_link_pulse), .pin_cal_en(pin_cal_en),
  .pin_tx_en(pin_tx_en), .irq_link(irq_link)
);

// File: tb/lane_ctl_regs_tb.sv
`timescale 1ns/1ps
module lane_ctl_regs_tb;
  localparam logic [15:0] A_RX = 16'h801C, A_INIT = 16'h8020,
                          A_STAT = 16'h8044, A_IRQ = 16'h8050;
  localparam logic [31:0] M_RX = 32'h8000_07F1, M_INIT = 32'h5;

  logic clk = 1'b0;
  logic rst_n;
  logic host_valid, host_write, host_ready, rsp_valid;
  logic [15:0] host_addr;
  logic [31:0] host_wdata, rsp_rdata;
  logic lane_tx_up, lane_tx_done, lane_cal_done, lane_link_pulse;
  logic pin_sw_ovrd, pin_pcs_rdy, pin_cdr_rst, pin_cal_en, pin_aux_iddq;
  logic pin_iddq, pin_data_en, pin_tx_en, pin_rx_en;
  logic [1:0] pin_sleep;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lane_ctl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_addr(host_addr), .host_wdata(host_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .lane_tx_up(lane_tx_up),
    .lane_tx_done(lane_tx_done), .lane_cal_done(lane_cal_done),
    .lane_link_pulse(lane_link_pulse), .pin_sw_ovrd(pin_sw_ovrd),
    .pin_pcs_rdy(pin_pcs_rdy), .pin_cdr_rst(pin_cdr_rst), .pin_cal_en(pin_cal_en),
    .pin_sleep(pin_sleep), .pin_aux_iddq(pin_aux_iddq), .pin_iddq(pin_iddq),
    .pin_data_en(pin_data_en), .pin_tx_en(pin_tx_en), .pin_rx_en(pin_rx_en)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] pins_word();
    return {pin_sw_ovrd, 20'd0, pin_pcs_rdy, pin_cdr_rst, pin_cal_en,
            pin_sleep, pin_aux_iddq, pin_iddq, 3'd0, pin_data_en};
  endfunction

  // issue one request at a negedge; response sampled at the next negedge
  task automatic xfer(input logic wr, input logic [15:0] a, input logic [31:0] d,
                      output logic [31:0] rd);
    host_valid = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_valid = 1'b0; host_write = 1'b0;
    check("R8 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    rd = rsp_rdata;
    if (wr) check("R8 write rdata", rd, 32'd0);
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [31:0] exp);
    logic [31:0] v;
    xfer(1'b0, a, 32'd0, v);
    check(req, v, exp);
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    logic [31:0] v;
    xfer(1'b1, a, d, v);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: got=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    rst_n = 1'b0; host_valid = 1'b0; host_write = 1'b0; host_addr = '0;
    host_wdata = '0; lane_tx_up = 1'b1; lane_tx_done = 1'b0;
    lane_cal_done = 1'b0; lane_link_pulse = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset pins", pins_word(), 32'h0000_00F0);
    check("R1 reset init pins", {30'd0, pin_rx_en, pin_tx_en}, 32'd0);
    check("R8 ready low in reset", {31'd0, host_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 ready after reset", {31'd0, host_ready}, 32'd1);
    check("R8 idle no rsp", {31'd0, rsp_valid}, 32'd0);

    // R1/R5/R7 address sweep over the window
    for (int a = 0; a < 64; a++) begin
      logic [15:0] ad = 16'h8000 + 16'(a * 4);
      exp = 32'd0;
      if (ad == A_RX) exp = 32'h0000_00F0;
      if (ad == A_STAT) exp = 32'd1;
      rd_chk("R1/R5/R7 sweep read", ad, exp);
    end
    // R7 writes to unmapped offsets change nothing
    for (int a = 0; a < 64; a++) begin
      logic [15:0] ad = 16'h8000 + 16'(a * 4);
      if (ad != A_RX && ad != A_INIT && ad != A_STAT && ad != A_IRQ)
        wr(ad, 32'hFFFF_FFFF);
    end
    wr(16'h0000, 32'hFFFF_FFFF);
    rd_chk("R7 rx untouched", A_RX, 32'h0000_00F0);
    rd_chk("R7 init untouched", A_INIT, 32'd0);
    rd_chk("R7 irq untouched", A_IRQ, 32'd0);
    rd_chk("R7 unmapped read", 16'h0000, 32'd0);
    check("R7 pins untouched", pins_word(), 32'h0000_00F0);

    // R2 walking ones on receive control
    for (int b = 0; b < 32; b++) begin
      exp = (32'd1 << b) & M_RX;
      wr(A_RX, 32'd1 << b);
      check("R2 rx pins", pins_word(), exp);
      rd_chk("R2 rx readback", A_RX, exp);
    end
    wr(A_RX, 32'hFFFF_FFFF);
    check("R2 rx all ones pins", pins_word(), M_RX);

    // R4 walking ones on init control
    for (int b = 0; b < 32; b++) begin
      exp = (32'd1 << b) & M_INIT;
      wr(A_INIT, 32'd1 << b);
      check("R4 init pins", {29'd0, pin_rx_en, 1'b0, pin_tx_en}, exp);
      rd_chk("R4 init readback", A_INIT, exp);
    end

    // R5 status follows lane, writes ignored
    lane_tx_up = 1'b0;
    rd_chk("R5 status low", A_STAT, 32'd0);
    wr(A_STAT, 32'hFFFF_FFFF);
    rd_chk("R5 status write ignored", A_STAT, 32'd0);
    lane_tx_up = 1'b1;
    rd_chk("R5 status high", A_STAT, 32'd1);

    // R3 calibration self-clear
    wr(A_RX, 32'h0000_0131);
    lane_cal_done = 1'b1;
    @(negedge clk);
    lane_cal_done = 1'b0;
    check("R3 cal cleared pin", pins_word(), 32'h0000_0031);
    rd_chk("R3 cal cleared read", A_RX, 32'h0000_0031);
    // R3 write wins over same-cycle completion
    lane_cal_done = 1'b1;
    wr(A_RX, 32'h0000_0100);
    lane_cal_done = 1'b0;
    check("R3 write wins pin", pins_word(), 32'h0000_0100);

    // R4 tx self-clear leaves rx enable
    wr(A_INIT, 32'h5);
    lane_tx_done = 1'b1;
    @(negedge clk);
    lane_tx_done = 1'b0;
    rd_chk("R4 tx cleared", A_INIT, 32'h4);
    lane_tx_done = 1'b1;
    wr(A_INIT, 32'h1);
    lane_tx_done = 1'b0;
    rd_chk("R4 write wins", A_INIT, 32'h1);

    // R6 sticky link bit
    lane_link_pulse = 1'b1;
    @(negedge clk);
    lane_link_pulse = 1'b0;
    repeat (4) @(negedge clk);
    rd_chk("R6 link sticky", A_IRQ, 32'h40);
    wr(A_IRQ, 32'hFFFF_FFBF);
    rd_chk("R6 write zero keeps", A_IRQ, 32'h40);
    wr(A_IRQ, 32'h40);
    rd_chk("R6 write one clears", A_IRQ, 32'h0);
    lane_link_pulse = 1'b1;
    wr(A_IRQ, 32'h40);
    lane_link_pulse = 1'b0;
    rd_chk("R6 set wins", A_IRQ, 32'h40);

    // R1 reset again mid-run
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset pins", pins_word(), 32'h0000_00F0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R1 re-reset irq", A_IRQ, 32'd0);
    rd_chk("R1 re-reset init", A_INIT, 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule